// File: doc/BRIEF.md
# Thermal Fan and Derating Controller

This block turns one snapshot of chassis temperatures into a cooling decision. Each snapshot carries an inlet reading, an outlet reading and several hotspot readings. Each reading comes with its own invalid flag. The controller takes the hottest usable hotspot and maps it through a four-point piecewise-linear curve to a fan PWM duty. The same temperature drives a protection ladder. The first rung cuts port rate, the second shuts ports, and the third caps power. Each rung has a trip point and a lower release point. The ladder can only step back down after the level has stayed unchanged for a minimum number of clock cycles.

Snapshots arrive on a valid/ready stream. `in_ready` is low while reset is asserted and high on every cycle after reset. The block never applies back-pressure, so each cycle with `in_valid` high is one accepted snapshot, and upstream may present a new one on every cycle. The outputs are plain registered status. They change only on the edge that accepts a snapshot and hold between snapshots.

A sensor counts as faulted when its invalid flag is set or when its reading is above a plausibility limit. A faulted snapshot drives the fans to full duty and raises a fault alarm. Readings from faulted hotspots are left out of the maximum.

Top module: `thermal_derate_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, before any snapshot is accepted, `fan_duty` is 255, `derate_level` is 0, and `alarm_fault` and `alarm_crit` are both low.
- R2: The controlling temperature is the largest reading among the hotspots that are not faulted. Inlet and outlet readings at or below the plausibility limit of 150 have no effect on `fan_duty` or `derate_level`.
- R3: With no fault, the duty follows breakpoints (32, 48, 64, 80) with duties (64, 96, 160, 255). The duty is interpolated linearly between breakpoints and rounded down. It is 64 below 32 and 255 at or above 80.
- R4: The outputs update only on a clock edge where `in_valid` and `in_ready` are both high, and they are visible from the next cycle. With `in_valid` low they hold, whatever the other inputs carry.
- R5: `in_bad` bit 0 flags the inlet, bit 1 flags the outlet and bit 2+i flags hotspot i. A reading above 150 counts the same as a set flag. Any faulted sensor in an accepted snapshot sets `fan_duty` to 255 and `alarm_fault` high. It also forbids a level step-down on that snapshot. A clean snapshot clears `alarm_fault`.
- R6: If the controlling temperature is at or above the trip point of the current level, the level rises by exactly one per snapshot. The trip points are 78 for leaving level 0, 88 for leaving level 1 and 95 for leaving level 2.
- R7: The level falls by one only when three conditions hold: the controlling temperature is below the release point of the current level (70 at level 1, 82 at level 2, 90 at level 3), the snapshot is fault-free, and the snapshot is accepted at least DWELL+1 = 17 cycles after the last level change. Between release and trip points the level holds.
- R8: `derate_level` codes are 0 for none, 1 for port-rate reduction, 2 for port shutdown and 3 for power cap. `alarm_crit` is high exactly when the level is 3.
- R9: `in_ready` is low during reset and high on every cycle after it. Every valid snapshot after reset is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Snapshot present |
| in_ready | output | 1 | Snapshot accepted when high |
| in_hot | input | N_HOT*TW | Hotspot readings, hotspot i in bits [i*TW +: TW] |
| in_inlet | input | TW | Inlet reading |
| in_outlet | input | TW | Outlet reading |
| in_bad | input | N_HOT+2 | Per-sensor invalid flags (bit 0 inlet, bit 1 outlet, bit 2+i hotspot i) |
| fan_duty | output | DW | Fan PWM duty |
| derate_level | output | clog2(LEVELS+1) | Protection level code |
| alarm_fault | output | 1 | Last accepted snapshot had a faulted sensor |
| alarm_crit | output | 1 | Level is at the top rung |

## Verification
A corrupt level register or a wrong trip comparison shows on `derate_level` in the cycle after the next accepted snapshot. A curve or maximum-selection fault shows on `fan_duty` in that same cycle. A broken dwell counter is the slow case. It only shows when a step-down is attempted, so the bench requests step-downs both immediately after a change and well beyond 17 cycles. A missed fault flag is caught by showing that the flagged reading did not raise the level and that the duty reached 255.

// File: rtl/thermal_pkg.sv
package thermal_pkg;

  typedef enum int {
    DR_NONE       = 0,
    DR_PORT_RATE  = 1,
    DR_PORT_COUNT = 2,
    DR_POWER_CAP  = 3
  } derate_code_e;

  // Linear blend between two breakpoints, rounded toward zero.
  function automatic int curve_interp(input int t, input int t_lo, input int t_hi,
                                      input int d_lo, input int d_hi);
    return d_lo + ((t - t_lo) * (d_hi - d_lo)) / (t_hi - t_lo);
  endfunction

endpackage

// File: rtl/thermal_hot_max.sv
module thermal_hot_max #(
  parameter int N  = 4,
  parameter int TW = 8
) (
  input  logic [N*TW-1:0] temps,
  input  logic [N-1:0]    bad,
  output logic [TW-1:0]   hottest
);

  logic [N:0][TW-1:0] run;

  assign run[0] = '0;

  for (genvar i = 0; i < N; i++) begin : g_stage
    logic [TW-1:0] cand;
    assign cand       = bad[i] ? '0 : temps[i*TW +: TW];
    assign run[i+1]   = (cand > run[i]) ? cand : run[i];
  end

  assign hottest = run[N];

endmodule

// File: rtl/thermal_fan_curve.sv
module thermal_fan_curve
  import thermal_pkg::*;
#(
  parameter int NPTS = 4,
  parameter int TW   = 8,
  parameter int DW   = 8,
  parameter logic [NPTS-1:0][TW-1:0] BP_T = {8'd80, 8'd64, 8'd48, 8'd32},
  parameter logic [NPTS-1:0][DW-1:0] BP_D = {8'd255, 8'd160, 8'd96, 8'd64}
) (
  input  logic [TW-1:0] temp,
  output logic [DW-1:0] duty
);

  localparam int NSEG = NPTS - 1;

  logic [NSEG-1:0]         hit;
  logic [NSEG-1:0][DW-1:0] seg_duty;

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    assign hit[s] = (temp >= BP_T[s]) && (temp < BP_T[s+1]);
    assign seg_duty[s] = DW'(curve_interp(int'(temp), int'(BP_T[s]), int'(BP_T[s+1]),
                                          int'(BP_D[s]), int'(BP_D[s+1])));
  end

  always_comb begin
    if (temp < BP_T[0]) duty = BP_D[0];
    else                duty = BP_D[NPTS-1];
    for (int s = 0; s < NSEG; s++) begin
      if (hit[s]) duty = seg_duty[s];
    end
  end

endmodule

// File: rtl/thermal_derate_fsm.sv
module thermal_derate_fsm #(
  parameter int TW     = 8,
  parameter int LEVELS = 3,
  parameter int DWELL  = 16,
  parameter logic [LEVELS-1:0][TW-1:0] ENTER_T = {8'd95, 8'd88, 8'd78},
  parameter logic [LEVELS-1:0][TW-1:0] EXIT_T  = {8'd90, 8'd82, 8'd70}
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          eval,
  input  logic [TW-1:0]                 hottest,
  input  logic                          fault,
  output logic [$clog2(LEVELS+1)-1:0]   level
);

  localparam int LW = $clog2(LEVELS + 1);
  localparam int CW = $clog2(DWELL + 1);

  logic [CW-1:0] age;
  logic [TW-1:0] enter_thr;
  logic [TW-1:0] exit_thr;
  logic          at_top;
  logic          step_up;
  logic          step_dn;

  always_comb begin
    enter_thr = '1;
    exit_thr  = '0;
    for (int k = 0; k < LEVELS; k++) begin
      if (level == LW'(k))     enter_thr = ENTER_T[k];
      if (level == LW'(k + 1)) exit_thr  = EXIT_T[k];
    end
  end

  assign at_top  = (level == LW'(LEVELS));
  assign step_up = eval && !at_top && (hottest >= enter_thr);
  assign step_dn = eval && !step_up && (level != '0) && !fault &&
                   (hottest < exit_thr) && (age == CW'(DWELL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= '0;
      age   <= '0;
    end else if (step_up) begin
      level <= level + 1'b1;
      age   <= '0;
    end else if (step_dn) begin
      level <= level - 1'b1;
      age   <= '0;
    end else if (age != CW'(DWELL)) begin
      age <= age + 1'b1;
    end
  end

endmodule

// File: rtl/thermal_derate_ctrl.sv
module thermal_derate_ctrl
  import thermal_pkg::*;
#(
  parameter int N_HOT  = 4,
  parameter int TW     = 8,
  parameter int DW     = 8,
  parameter int NPTS   = 4,
  parameter int LEVELS = 3,
  parameter int DWELL  = 16,
  parameter logic [TW-1:0] PLAUS_MAX = 8'd150,
  parameter logic [NPTS-1:0][TW-1:0]   BP_T    = {8'd80, 8'd64, 8'd48, 8'd32},
  parameter logic [NPTS-1:0][DW-1:0]   BP_D    = {8'd255, 8'd160, 8'd96, 8'd64},
  parameter logic [LEVELS-1:0][TW-1:0] ENTER_T = {8'd95, 8'd88, 8'd78},
  parameter logic [LEVELS-1:0][TW-1:0] EXIT_T  = {8'd90, 8'd82, 8'd70}
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [N_HOT*TW-1:0]         in_hot,
  input  logic [TW-1:0]               in_inlet,
  input  logic [TW-1:0]               in_outlet,
  input  logic [N_HOT+1:0]            in_bad,
  output logic [DW-1:0]               fan_duty,
  output logic [$clog2(LEVELS+1)-1:0] derate_level,
  output logic                        alarm_fault,
  output logic                        alarm_crit
);

  localparam int NS = N_HOT + 2;
  localparam int LW = $clog2(LEVELS + 1);

  logic [NS-1:0][TW-1:0] readings;
  logic [NS-1:0]         sens_bad;
  logic                  fault_any;
  logic                  accept;
  logic [TW-1:0]         hottest;
  logic [DW-1:0]         curve_duty;

  assign readings = {in_hot, in_outlet, in_inlet};

  for (genvar i = 0; i < NS; i++) begin : g_plaus
    assign sens_bad[i] = in_bad[i] || (readings[i] > PLAUS_MAX);
  end

  assign fault_any = |sens_bad;
  assign accept    = in_valid && in_ready;

  thermal_hot_max #(.N(N_HOT), .TW(TW)) u_max (
    .temps   (in_hot),
    .bad     (sens_bad[NS-1:2]),
    .hottest (hottest)
  );

  thermal_fan_curve #(
    .NPTS(NPTS), .TW(TW), .DW(DW), .BP_T(BP_T), .BP_D(BP_D)
  ) u_curve (
    .temp (hottest),
    .duty (curve_duty)
  );

  thermal_derate_fsm #(
    .TW(TW), .LEVELS(LEVELS), .DWELL(DWELL), .ENTER_T(ENTER_T), .EXIT_T(EXIT_T)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .eval    (accept),
    .hottest (hottest),
    .fault   (fault_any),
    .level   (derate_level)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_ready    <= 1'b0;
      fan_duty    <= '1;
      alarm_fault <= 1'b0;
    end else begin
      in_ready <= 1'b1;
      if (accept) begin
        fan_duty    <= fault_any ? '1 : curve_duty;
        alarm_fault <= fault_any;
      end
    end
  end

  assign alarm_crit = (derate_level == LW'(LEVELS));

endmodule

// File: rtl/thermal_derate_chk.sv
module thermal_derate_chk #(
  parameter int NS    = 6,
  parameter int DW    = 8,
  parameter int LW    = 2,
  parameter int DWELL = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [NS-1:0] in_bad,
  input logic [DW-1:0] fan_duty,
  input logic [LW-1:0] derate_level,
  input logic          alarm_fault
);

  localparam int CW = $clog2(DWELL + 1);

  logic          acc;
  logic [LW-1:0] lvl_q;
  logic [CW-1:0] age;

  assign acc = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      age   <= '0;
    end else begin
      lvl_q <= derate_level;
      if (derate_level != lvl_q)   age <= '0;
      else if (age != CW'(DWELL))  age <= age + 1'b1;
    end
  end

  a_r4_hold_without_sample: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(acc) |-> ($stable(fan_duty) && $stable(derate_level)));

  a_r5_fault_full_duty: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc && (|in_bad)) |-> (fan_duty == {DW{1'b1}}));

  a_r5_fault_alarm: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc && (|in_bad)) |-> alarm_fault);

  a_r5_no_drop_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc && (|in_bad)) |-> (derate_level >= $past(derate_level)));

  a_r6_single_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (derate_level > $past(derate_level)) |-> (derate_level == $past(derate_level) + LW'(1)));

  a_r7_dwell_before_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (derate_level < $past(derate_level)) |->
      ((age >= CW'(DWELL)) && (derate_level == $past(derate_level) - LW'(1))));

endmodule

bind thermal_derate_ctrl thermal_derate_chk #(
  .NS(N_HOT + 2), .DW(DW), .LW($clog2(LEVELS + 1)), .DWELL(DWELL)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .in_bad       (in_bad),
  .fan_duty     (fan_duty),
  .derate_level (derate_level),
  .alarm_fault  (alarm_fault)
);

// File: tb/thermal_derate_ctrl_test.sv
`timescale 1ns/1ps
module thermal_derate_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_hot = '0;
  logic [7:0]  in_inlet = '0;
  logic [7:0]  in_outlet = '0;
  logic [5:0]  in_bad = '0;
  logic [7:0]  fan_duty;
  logic [1:0]  derate_level;
  logic        alarm_fault;
  logic        alarm_crit;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  thermal_derate_ctrl uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_hot(in_hot), .in_inlet(in_inlet), .in_outlet(in_outlet), .in_bad(in_bad),
    .fan_duty(fan_duty), .derate_level(derate_level),
    .alarm_fault(alarm_fault), .alarm_crit(alarm_crit)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic send(input int h0, input int h1, input int h2, input int h3,
                      input int inl, input int outl, input logic [5:0] bad);
    @(negedge clk);
    in_hot    = {8'(h3), 8'(h2), 8'(h1), 8'(h0)};
    in_inlet  = 8'(inl);
    in_outlet = 8'(outl);
    in_bad    = bad;
    in_valid  = 1'b1;
    @(negedge clk);
    in_valid  = 1'b0;
    in_bad    = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    idle(3);
    chk("R9", "ready in reset", int'(in_ready), 0);
    chk("R1", "duty in reset", int'(fan_duty), 255);
    rst_n = 1'b1;
    idle(1);
    chk("R9", "ready after reset", int'(in_ready), 1);
    chk("R1", "duty after reset", int'(fan_duty), 255);
    chk("R1", "level after reset", int'(derate_level), 0);
    chk("R1", "fault alarm after reset", int'(alarm_fault), 0);
    chk("R1", "crit alarm after reset", int'(alarm_crit), 0);
  endtask

  task automatic t_curve;
    send(20, 10, 5, 15, 25, 30, '0);
    chk("R3", "duty below first breakpoint", int'(fan_duty), 64);
    send(10, 40, 5, 30, 25, 30, '0);
    chk("R2", "duty from hottest hotspot", int'(fan_duty), 80);
    send(56, 0, 0, 0, 25, 30, '0);
    chk("R3", "duty mid second segment", int'(fan_duty), 128);
    send(0, 0, 72, 0, 25, 30, '0);
    chk("R3", "duty third segment rounded down", int'(fan_duty), 207);
    chk("R3", "level stays 0 below trip", int'(derate_level), 0);
    send(48, 1, 2, 3, 25, 30, '0);
    chk("R3", "duty at breakpoint", int'(fan_duty), 96);
    send(20, 20, 20, 20, 140, 145, '0);
    chk("R2", "hot inlet/outlet ignored duty", int'(fan_duty), 64);
    chk("R2", "hot inlet/outlet ignored alarm", int'(alarm_fault), 0);
    chk("R2", "hot inlet/outlet ignored level", int'(derate_level), 0);
  endtask

  task automatic t_hold;
    @(negedge clk);
    in_hot = {8'd99, 8'd99, 8'd99, 8'd99};
    in_bad = 6'b111111;
    idle(6);
    chk("R4", "duty holds without valid", int'(fan_duty), 64);
    chk("R4", "level holds without valid", int'(derate_level), 0);
    chk("R4", "alarm holds without valid", int'(alarm_fault), 0);
    in_bad = '0;
  endtask

  task automatic t_fault;
    send(10, 10, 10, 10, 20, 20, 6'b000100);
    chk("R5", "flagged hotspot duty", int'(fan_duty), 255);
    chk("R5", "flagged hotspot alarm", int'(alarm_fault), 1);
    send(10, 120, 10, 10, 20, 20, 6'b001000);
    chk("R5", "flagged hot reading excluded from level", int'(derate_level), 0);
    send(10, 10, 10, 10, 20, 160, '0);
    chk("R5", "implausible outlet duty", int'(fan_duty), 255);
    chk("R5", "implausible outlet alarm", int'(alarm_fault), 1);
    send(30, 155, 30, 30, 20, 20, '0);
    chk("R5", "implausible hotspot excluded", int'(derate_level), 0);
    send(10, 10, 10, 10, 20, 20, 6'b000001);
    chk("R5", "flagged inlet duty", int'(fan_duty), 255);
    send(10, 10, 10, 10, 20, 20, '0);
    chk("R5", "clean sample clears alarm", int'(alarm_fault), 0);
    chk("R5", "clean sample duty", int'(fan_duty), 64);
  endtask

  task automatic t_derate;
    send(74, 74, 74, 74, 25, 30, '0);
    chk("R6", "below trip no derate", int'(derate_level), 0);
    chk("R3", "duty at 74", int'(fan_duty), 219);
    send(10, 10, 100, 10, 25, 30, '0);
    chk("R6", "single step from 0", int'(derate_level), 1);
    chk("R3", "duty above last breakpoint", int'(fan_duty), 255);
    send(10, 10, 100, 10, 25, 30, '0);
    chk("R6", "second step", int'(derate_level), 2);
    chk("R8", "no crit at level 2", int'(alarm_crit), 0);
    send(10, 10, 100, 10, 25, 30, '0);
    chk("R6", "third step", int'(derate_level), 3);
    chk("R8", "crit at level 3", int'(alarm_crit), 1);
    idle(20);
    send(92, 10, 10, 10, 25, 30, '0);
    chk("R7", "hold inside band at level 3", int'(derate_level), 3);
    send(85, 10, 10, 10, 25, 30, '0);
    chk("R7", "release after dwell", int'(derate_level), 2);
    chk("R8", "crit clears", int'(alarm_crit), 0);
    send(60, 10, 10, 10, 25, 30, '0);
    chk("R7", "no release before dwell", int'(derate_level), 2);
    idle(20);
    send(75, 10, 10, 10, 25, 30, '0);
    chk("R7", "release to level 1", int'(derate_level), 1);
    idle(20);
    send(74, 10, 10, 10, 25, 30, '0);
    chk("R7", "hold inside band at level 1", int'(derate_level), 1);
    idle(20);
    send(60, 60, 60, 60, 25, 30, 6'b000100);
    chk("R5", "faulted sample blocks release", int'(derate_level), 1);
    send(60, 60, 60, 60, 25, 30, '0);
    chk("R7", "clean release to 0", int'(derate_level), 0);
    chk("R3", "duty at 60", int'(fan_duty), 144);
  endtask

  initial begin
    #500us;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_curve();
    t_hold();
    t_fault();
    t_derate();
    idle(2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule